// File: doc/BRIEF.md
# Privilege-Filtered Chainable Event Counter Bank

This block holds a small bank of event counters that software uses to measure how often hardware events occur. Each counter has its own control word. The control word picks which external event strobe the counter watches. It also holds a set of freeze bits that stop counting in chosen processor states: supervisor or user privilege, and a marked or unmarked thread. A per-counter freeze bit stops one counter, and a single global freeze bit stops the whole bank. Any of the freeze conditions overrides all others.

A counter other than the first can take, in place of a strobe, the wrap carry of the counter just below it. A chained pair then acts as one count twice as wide. The lower counter's wrap and the upper counter's increment land on the same clock edge.

Every counter reports a one-cycle wrap pulse and a sticky wrap flag. All state is reached through one write port and one combinational read port. The port has separate write and read addresses and uses a flat address map.

Top module: `evcnt_bank`

## Requirements
- R1: After reset, every counter, every control word and the global freeze bit read zero, and no wrap pulse or sticky flag is set.
- R2: An unfrozen counter with the chain bit (control bit 5) clear adds exactly one on each cycle in which the strobe chosen by control bits [10:8] is high. It holds its value on every other cycle.
- R3: Control bit 1 stops counting while `priv_sup` is 1. Control bit 2 stops counting while `priv_sup` is 0. With both set, the counter never counts.
- R4: Control bit 3 stops counting while `mark` is 1. Control bit 4 stops counting while `mark` is 0. With both set, the counter never counts.
- R5: Control bit 0 (local freeze) stops its own counter. Bit 0 of the global word at address 8 stops every counter. Each overrides the state-based bits.
- R6: With the chain bit set, counter n>0 counts the wrap carries of counter n-1, subject to its own freeze bits. The pair then counts as one 64-bit value. Counter 0 with the chain bit set never counts.
- R7: A wrap is an increment taken from all ones. `ovf_pulse[n]` is high for exactly the one cycle after the wrapping edge, when the counter reads zero, and `ovf_sticky[n]` becomes 1.
- R8: A write to a counter's value address (n) or its control address (4+n) clears that counter's sticky flag. A value write loads the written data and wins over an increment in the same cycle, so no wrap can occur on that edge.
- R9: `rd_data` returns, with no cycle of delay, the counter value at addresses 0-3, the 11-bit control word at addresses 4-7 and the global freeze bit at address 8. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_strobe | input | 8 | Event strobes, one per selectable event |
| priv_sup | input | 1 | 1 = supervisor state, 0 = user state |
| mark | input | 1 | Current thread mark bit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data |
| ctr_val | output | 128 | Counter values, counter n at bits [32n+31:32n] |
| ovf_pulse | output | 4 | One-cycle wrap pulse per counter |
| ovf_sticky | output | 4 | Sticky wrap flag per counter |

## Verification
The bench builds the bank with its default parameters: four 32-bit counters and eight strobes. This keeps the full carry from a lower counter into its chained neighbour within reach, and it lets every value of the 3-bit select field be driven. Full 32-bit counters cannot wrap in a short run, so the bench writes values just below all ones to reach wrap, chained carry and sticky behaviour within a few cycles. A long stretch of random writes, strobes and privilege and mark patterns is checked against a behavioural model on every cycle. This covers the rarer combinations: writes that collide with a wrap, control writes in the same cycle as a carry, and chaining under freeze.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
   // bit positions inside a counter control word
   localparam int CB_FRZ     = 0;  // local freeze
   localparam int CB_FSUP    = 1;  // freeze in supervisor state
   localparam int CB_FUSR    = 2;  // freeze in user state
   localparam int CB_FMK1    = 3;  // freeze while mark = 1
   localparam int CB_FMK0    = 4;  // freeze while mark = 0
   localparam int CB_CHAIN   = 5;  // take lower neighbour's carry as event
   localparam int CB_SEL_LSB = 8;  // event select field
endpackage

// File: rtl/evcnt_gate.sv
module evcnt_gate (
   input  logic frz_local,
   input  logic frz_sup,
   input  logic frz_usr,
   input  logic frz_mk1,
   input  logic frz_mk0,
   input  logic frz_all,
   input  logic priv_sup,
   input  logic mark,
   output logic cnt_en
);
   logic state_block;

   always_comb begin
      state_block = (priv_sup & frz_sup) | (~priv_sup & frz_usr)
                  | (mark & frz_mk1)     | (~mark & frz_mk0);
      cnt_en      = ~(frz_all | frz_local | state_block);
   end

   // R4
   always_comb begin
      frz_mark_both_chk: assert (!(frz_mk1 && frz_mk0) || !cnt_en);
   end
endmodule

// File: rtl/evcnt_cell.sv
module evcnt_cell
   import evcnt_pkg::*;
#(
   parameter int CTR_W     = 32,
   parameter int NUM_EV    = 8,
   parameter bit HAS_CHAIN = 1'b1,
   localparam int EVSEL_W  = $clog2(NUM_EV),
   localparam int CTL_W    = CB_SEL_LSB + EVSEL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NUM_EV-1:0] ev_strobe,
   input  logic             priv_sup,
   input  logic             mark,
   input  logic             frz_all,
   input  logic             carry_in,
   input  logic             wr_val,
   input  logic             wr_ctl,
   input  logic [CTR_W-1:0] wr_data,
   output logic [CTR_W-1:0] val_q,
   output logic [CTL_W-1:0] ctl_q,
   output logic             carry_out,
   output logic             ovf_pulse,
   output logic             ovf_sticky
);
   logic             cnt_en;
   logic             ev_in;
   logic             inc;
   logic [EVSEL_W-1:0] sel;

   assign sel = ctl_q[CB_SEL_LSB +: EVSEL_W];

   evcnt_gate u_gate (
      .frz_local (ctl_q[CB_FRZ]),
      .frz_sup   (ctl_q[CB_FSUP]),
      .frz_usr   (ctl_q[CB_FUSR]),
      .frz_mk1   (ctl_q[CB_FMK1]),
      .frz_mk0   (ctl_q[CB_FMK0]),
      .frz_all   (frz_all),
      .priv_sup  (priv_sup),
      .mark      (mark),
      .cnt_en    (cnt_en)
   );

   generate
      if (HAS_CHAIN) begin : g_chain
         assign ev_in = ctl_q[CB_CHAIN] ? carry_in : ev_strobe[sel];
      end else begin : g_nochain
         logic unused_carry;
         assign unused_carry = carry_in;
         assign ev_in = ctl_q[CB_CHAIN] ? 1'b0 : ev_strobe[sel];
      end
   endgenerate

   assign inc       = cnt_en & ev_in;
   assign carry_out = inc & (&val_q) & ~wr_val;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val_q      <= '0;
         ctl_q      <= '0;
         ovf_pulse  <= 1'b0;
         ovf_sticky <= 1'b0;
      end else begin
         if (wr_val)
            val_q <= wr_data;
         else if (inc)
            val_q <= val_q + 1'b1;
         if (wr_ctl)
            ctl_q <= wr_data[CTL_W-1:0];
         ovf_pulse <= carry_out;
         if (wr_val || wr_ctl)
            ovf_sticky <= 1'b0;
         else if (carry_out)
            ovf_sticky <= 1'b1;
      end
   end

   // R8
   wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(wr_val) |-> val_q == $past(wr_data));
   // R2
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !$past(wr_val) |->
         (val_q == $past(val_q)) || (val_q == $past(val_q) + 1'b1));
   // R5
   frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !$past(wr_val) && ($past(frz_all) || $past(ctl_q[CB_FRZ]))
         |-> $stable(val_q));
   // R7
   ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> val_q == '0);
   // R7
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && ovf_pulse && !$past(wr_ctl) |-> ovf_sticky);
endmodule

// File: rtl/evcnt_bank.sv
module evcnt_bank
   import evcnt_pkg::*;
#(
   parameter int NUM_CTR  = 4,
   parameter int CTR_W    = 32,
   parameter int NUM_EV   = 8,
   localparam int EVSEL_W = $clog2(NUM_EV),
   localparam int CTL_W   = CB_SEL_LSB + EVSEL_W,
   localparam int ADDR_W  = $clog2(2 * NUM_CTR + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_EV-1:0]        ev_strobe,
   input  logic                     priv_sup,
   input  logic                     mark,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [CTR_W-1:0]         wr_data,
   input  logic [ADDR_W-1:0]        rd_addr,
   output logic [CTR_W-1:0]         rd_data,
   output logic [NUM_CTR*CTR_W-1:0] ctr_val,
   output logic [NUM_CTR-1:0]       ovf_pulse,
   output logic [NUM_CTR-1:0]       ovf_sticky
);
   localparam logic [ADDR_W-1:0] GLB_ADDR = ADDR_W'(2 * NUM_CTR);

   generate
      if (NUM_CTR < 1) begin : g_bad_num
         $error("NUM_CTR must be at least 1");
      end
      if (NUM_EV < 2 || (NUM_EV & (NUM_EV - 1)) != 0) begin : g_bad_ev
         $error("NUM_EV must be a power of two, at least 2");
      end
      if (CTL_W > CTR_W) begin : g_bad_w
         $error("CTR_W too narrow for the control word");
      end
   endgenerate

   logic                   frz_all_q;
   logic [NUM_CTR-1:0]     carry;
   logic [NUM_CTR-1:0]     wr_val;
   logic [NUM_CTR-1:0]     wr_ctl;
   logic [CTR_W-1:0]       val   [NUM_CTR];
   logic [CTL_W-1:0]       ctl   [NUM_CTR];

   always_ff @(posedge clk) begin
      if (!rst_n)
         frz_all_q <= 1'b0;
      else if (wr_en && wr_addr == GLB_ADDR)
         frz_all_q <= wr_data[0];
   end

   generate
      for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
         logic cin;
         assign wr_val[n] = wr_en && (wr_addr == ADDR_W'(n));
         assign wr_ctl[n] = wr_en && (wr_addr == ADDR_W'(NUM_CTR + n));
         if (n > 0) begin : g_cin
            assign cin = carry[n-1];
         end else begin : g_cin0
            assign cin = 1'b0;
         end

         evcnt_cell #(
            .CTR_W     (CTR_W),
            .NUM_EV    (NUM_EV),
            .HAS_CHAIN (n > 0)
         ) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .ev_strobe  (ev_strobe),
            .priv_sup   (priv_sup),
            .mark       (mark),
            .frz_all    (frz_all_q),
            .carry_in   (cin),
            .wr_val     (wr_val[n]),
            .wr_ctl     (wr_ctl[n]),
            .wr_data    (wr_data),
            .val_q      (val[n]),
            .ctl_q      (ctl[n]),
            .carry_out  (carry[n]),
            .ovf_pulse  (ovf_pulse[n]),
            .ovf_sticky (ovf_sticky[n])
         );
         assign ctr_val[n*CTR_W +: CTR_W] = val[n];
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int n = 0; n < NUM_CTR; n++) begin
         if (rd_addr == ADDR_W'(n))
            rd_data = val[n];
         if (rd_addr == ADDR_W'(NUM_CTR + n))
            rd_data = CTR_W'(ctl[n]);
      end
      if (rd_addr == GLB_ADDR)
         rd_data = CTR_W'(frz_all_q);
   end

   // R5
   glb_frz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(frz_all_q) && !$past(wr_en) |-> $stable(ctr_val));
   // R8
   one_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_val, wr_ctl}));
endmodule

// File: tb/evcnt_bank_tb.sv
`timescale 1ns/100ps
module evcnt_bank_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  ev_strobe = '0;
   logic        priv_sup = 1'b0;
   logic        mark = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [127:0] ctr_val;
   logic [3:0]  ovf_pulse;
   logic [3:0]  ovf_sticky;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [31:0] m_val [4];
   logic [10:0] m_ctl [4];
   logic        m_glb;
   logic [3:0]  m_pulse;
   logic [3:0]  m_sticky;

   always #2.5 clk = ~clk;

   evcnt_bank u_dut (
      .clk(clk), .rst_n(rst_n), .ev_strobe(ev_strobe), .priv_sup(priv_sup),
      .mark(mark), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .ctr_val(ctr_val),
      .ovf_pulse(ovf_pulse), .ovf_sticky(ovf_sticky)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] exp_rd(input logic [3:0] a);
      if (a < 4)       return m_val[a[1:0]];
      else if (a < 8)  return {21'd0, m_ctl[a[1:0]]};
      else if (a == 8) return {31'd0, m_glb};
      else             return 32'd0;
   endfunction

   // compare the previous edge's result, then apply new inputs and predict the next edge
   task automatic step(input logic we, input logic [3:0] wa, input logic [31:0] wd,
                       input logic [7:0] evs, input logic sup, input logic mk,
                       input logic [3:0] ra);
      logic c_prev;
      logic [31:0] nv [4];
      @(negedge clk);
      for (int n = 0; n < 4; n++) chk("R2 value", ctr_val[n*32 +: 32], m_val[n]);
      chk("R7 pulse", {28'd0, ovf_pulse}, {28'd0, m_pulse});
      chk("R8 sticky", {28'd0, ovf_sticky}, {28'd0, m_sticky});
      chk("R9 read", rd_data, exp_rd(rd_addr));
      wr_en = we; wr_addr = wa; wr_data = wd; ev_strobe = evs;
      priv_sup = sup; mark = mk; rd_addr = ra;
      c_prev = 1'b0;
      for (int n = 0; n < 4; n++) begin
         logic [10:0] c;
         logic en, evin, wv, wc, inc, cy;
         c    = m_ctl[n];
         en   = !m_glb && !c[0] && !(sup && c[1]) && !(!sup && c[2])
                && !(mk && c[3]) && !(!mk && c[4]);
         evin = c[5] ? ((n == 0) ? 1'b0 : c_prev) : evs[c[10:8]];
         wv   = we && (wa == 4'(n));
         wc   = we && (wa == 4'(n + 4));
         inc  = en && evin;
         cy   = inc && (m_val[n] == 32'hFFFF_FFFF) && !wv;
         nv[n] = wv ? wd : (inc ? m_val[n] + 32'd1 : m_val[n]);
         m_pulse[n] = cy;
         if (wv || wc) m_sticky[n] = 1'b0;
         else if (cy)  m_sticky[n] = 1'b1;
         if (wc) m_ctl[n] = wd[10:0];
         c_prev = cy;
      end
      for (int n = 0; n < 4; n++) m_val[n] = nv[n];
      if (we && wa == 4'd8) m_glb = wd[0];
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      step(1'b1, a, d, 8'h00, priv_sup, mark, rd_addr);
   endtask

   task automatic idle(input logic [7:0] evs, input logic sup, input logic mk);
      step(1'b0, 4'd0, 32'd0, evs, sup, mk, rd_addr);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int n = 0; n < 4; n++) begin m_val[n] = '0; m_ctl[n] = '0; end
      m_glb = 1'b0; m_pulse = '0; m_sticky = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      idle(8'h00, 1'b0, 1'b0);
      for (int n = 0; n < 4; n++) chk("R1 counter", ctr_val[n*32 +: 32], 32'd0);
      chk("R1 flags", {24'd0, ovf_pulse, ovf_sticky}, 32'd0);
      step(1'b0, 4'd0, 32'd0, 8'h00, 1'b0, 1'b0, 4'd8);
      idle(8'h00, 1'b0, 1'b0);
      chk("R1 global", rd_data, 32'd0);

      // R2: select strobe 2, ten events
      wr(4'd4, 32'h0000_0200);
      repeat (10) idle(8'h04, 1'b0, 1'b0);
      idle(8'hFB, 1'b0, 1'b0);
      chk("R2 ten events", ctr_val[31:0], 32'd10);

      // R3: supervisor freeze
      wr(4'd4, 32'h0000_0202);
      repeat (5) idle(8'h04, 1'b1, 1'b0);
      idle(8'h00, 1'b0, 1'b0);
      chk("R3 frozen in supervisor", ctr_val[31:0], 32'd10);
      repeat (5) idle(8'h04, 1'b0, 1'b1);
      idle(8'h00, 1'b0, 1'b0);
      chk("R3 counts in user", ctr_val[31:0], 32'd15);

      // R4: both mark freezes, then mark-1 freeze
      wr(4'd4, 32'h0000_0218);
      for (int i = 0; i < 6; i++) idle(8'h04, i[0], i[1]);
      idle(8'h00, 1'b0, 1'b0);
      chk("R4 both mark freezes", ctr_val[31:0], 32'd15);
      wr(4'd4, 32'h0000_0208);
      repeat (3) idle(8'h04, 1'b0, 1'b1);
      repeat (4) idle(8'h04, 1'b1, 1'b0);
      idle(8'h00, 1'b0, 1'b0);
      chk("R4 mark-1 freeze", ctr_val[31:0], 32'd19);

      // R5: global and local freeze
      wr(4'd4, 32'h0000_0200);
      wr(4'd8, 32'd1);
      repeat (4) idle(8'h04, 1'b0, 1'b0);
      idle(8'h00, 1'b0, 1'b0);
      chk("R5 global freeze", ctr_val[31:0], 32'd19);
      wr(4'd8, 32'd0);
      wr(4'd4, 32'h0000_0201);
      repeat (4) idle(8'h04, 1'b0, 1'b0);
      idle(8'h00, 1'b0, 1'b0);
      chk("R5 local freeze", ctr_val[31:0], 32'd19);

      // R6 / R7: chained pair across a wrap
      wr(4'd4, 32'h0000_0200);
      wr(4'd5, 32'h0000_0020);
      wr(4'd0, 32'hFFFF_FFFE);
      wr(4'd1, 32'd5);
      idle(8'h04, 1'b0, 1'b0);
      idle(8'h04, 1'b0, 1'b0);
      idle(8'h04, 1'b0, 1'b0);
      chk("R7 pulse on wrap", {31'd0, ovf_pulse[0]}, 32'd1);
      chk("R7 wrapped to zero", ctr_val[31:0], 32'd0);
      chk("R6 carry into upper", ctr_val[63:32], 32'd6);
      idle(8'h00, 1'b0, 1'b0);
      chk("R7 pulse one cycle", {31'd0, ovf_pulse[0]}, 32'd0);
      chk("R7 sticky set", {31'd0, ovf_sticky[0]}, 32'd1);
      chk("R6 lower continues", ctr_val[31:0], 32'd1);

      // R6: counter 0 has no chain source
      wr(4'd4, 32'h0000_0220);
      repeat (4) idle(8'hFF, 1'b0, 1'b0);
      idle(8'h00, 1'b0, 1'b0);
      chk("R6 counter0 chain idle", ctr_val[31:0], 32'd1);

      // R8: control write clears sticky; value write beats increment
      wr(4'd4, 32'h0000_0200);
      idle(8'h00, 1'b0, 1'b0);
      chk("R8 sticky cleared", {31'd0, ovf_sticky[0]}, 32'd0);
      step(1'b1, 4'd0, 32'd100, 8'h04, 1'b0, 1'b0, 4'd4);
      idle(8'h00, 1'b0, 1'b0);
      chk("R8 write wins", ctr_val[31:0], 32'd100);
      chk("R9 control readback", rd_data, 32'h0000_0200);

      // random traffic against the model
      for (int i = 0; i < 3000; i++) begin
         logic we;
         logic [3:0] wa;
         logic [31:0] wd;
         we = ($urandom % 4) == 0;
         wa = 4'($urandom % 10);
         if (wa < 4)       wd = 32'hFFFF_FFF0 | ($urandom % 16);
         else if (wa < 8)  wd = ($urandom & 32'h0000_0720) | ((($urandom % 3) == 0) ? ($urandom & 32'h1F) : 32'd0);
         else              wd = {31'd0, (($urandom % 8) == 0)};
         step(we, wa, wd, 8'($urandom), 1'($urandom), 1'($urandom), 4'($urandom % 10));
      end
      idle(8'h00, 1'b0, 1'b0);

      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule